// File: doc/BRIEF.md
# Interrupt enable and pending controller

A register block that keeps three state bits per interrupt line (enabled, pending, active) and one 8-bit priority field per line. Lines are grouped in banks of 32. Software changes the enable and pending state through paired registers: a write-one-to-set register and a write-one-to-clear register that act on the same stored bits, so one line can be changed without a read-modify-write. A read-only type register reports how many banks exist.

Hardware interrupt inputs are edge-sensitive: a rising level latches the line's pending bit. The active bits are not writable from the bus. An acknowledge port sets them and a completion port clears them. A combinational finder reports the lowest-numbered line that is pending and not excluded by a caller mask. A separate flag reports whether any enabled, unmasked line is pending.

The bus is a single-cycle port. A write takes effect at the clock edge where `bus_req_i` and `bus_we_i` are high. Read data is combinational from the address. Byte address bits [1:0] must be zero for any register to respond.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Offset 0x004 reads NUM_BANKS-1 in bits [3:0] and zero in bits [31:4].
- R2: For bank n, writing to 0x100+4n sets each enable bit whose write bit is 1, and writing to 0x180+4n clears each such bit. Write bits of 0 change nothing. Both addresses read the current enable state.
- R3: For bank n, writing to 0x200+4n sets pending bits and writing to 0x280+4n clears them, with the same one-acts, zero-ignored rule. Both addresses read the current pending state.
- R4: Bit m of bank n, `irq_i[m+32n]`, `mask_i[m+32n]` and finder index m+32n all refer to the same line.
- R5: When 16 banks are configured, bits [31:16] of bank 15 read zero and ignore writes. Banks at index NUM_BANKS or above read zero and ignore writes.
- R6: Priority word w at 0x400+4w holds line 4w in bits [7:0], line 4w+1 in bits [15:8], line 4w+2 in bits [23:16] and line 4w+3 in bits [31:24]. It is readable and writable. Words with no implemented lines read zero.
- R7: A 0-to-1 change on `irq_i` sets that line's pending bit at the next clock edge. A level held high does not set the bit again after it is cleared. If a new event and a clear-pending write hit the same bit in one cycle, the bit ends up set.
- R8: `find_valid_o` is 1 when some line is pending with its mask bit 0. Enable is not considered. `find_id_o` is then the lowest such line. With no such line, `find_valid_o` is 0 and `find_id_o` is 0.
- R9: `any_pending_o` is 1 exactly when some line is pending, enabled and unmasked.
- R10: The active bits read at 0x300+4n and ignore bus writes. An acknowledge sets the bit of `ack_id_i` and a completion clears the bit of `done_id_i`. When both name the same line in one cycle, the bit is set. Ids of unimplemented lines are ignored.
- R11: After reset every enable, pending, active and priority bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 for a write |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_i | input | NUM_LINES | Hardware interrupt levels |
| mask_i | input | NUM_LINES | Lines excluded from finder and any-pending flag |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | ID_W | Line being acknowledged |
| done_valid_i | input | 1 | Completion strobe |
| done_id_i | input | ID_W | Line being completed |
| find_valid_o | output | 1 | A pending, unmasked line exists |
| find_id_o | output | ID_W | Lowest such line |
| any_pending_o | output | 1 | Some pending, enabled, unmasked line exists |

## Verification
The hardest case to reach from the ports is a clear-pending write and a fresh input edge landing on the same bit in the same cycle. The stimulus first drops the input and then, at one falling clock edge, raises the input and presents the clear write together. A second difficult area is the partial last bank and the unimplemented ids. It is exercised by writing all ones to bank 15 and bank 16 and by acknowledging line 500, then reading back through the bank-15 active register. The finder's ordering is checked by walking a mask over three pending lines in different banks, with enables held off so that the finder and the any-pending flag are seen to differ.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_W      = 32;
  localparam int unsigned MAX_BANKS   = 16;
  localparam int unsigned LAST_BANK_W = 16;
  localparam int unsigned PRIO_W      = 8;
  localparam int unsigned PRIO_MAX_WORDS = 252;

  typedef enum logic [2:0] {
    RG_NONE, RG_TYPE, RG_SET_EN, RG_CLR_EN,
    RG_SET_PEND, RG_CLR_PEND, RG_ACTIVE, RG_PRIO
  } reg_kind_e;

  function automatic int unsigned line_count(int unsigned banks);
    return (banks >= MAX_BANKS) ? (MAX_BANKS - 1) * BANK_W + LAST_BANK_W
                                : banks * BANK_W;
  endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
(
  input  logic [11:0] addr_i,
  output reg_kind_e   kind_o,
  output logic [4:0]  bank_o,
  output logic [7:0]  word_o
);
  always_comb begin
    kind_o = RG_NONE;
    bank_o = addr_i[6:2];
    word_o = addr_i[9:2];
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i[11:2] == 10'd1) begin
        kind_o = RG_TYPE;
      end else if (addr_i[11:10] == 2'b01) begin
        if (32'(addr_i[9:2]) < PRIO_MAX_WORDS) kind_o = RG_PRIO;
      end else begin
        case (addr_i[11:7])
          5'h02:   kind_o = RG_SET_EN;
          5'h03:   kind_o = RG_CLR_EN;
          5'h04:   kind_o = RG_SET_PEND;
          5'h05:   kind_o = RG_CLR_PEND;
          5'h06:   kind_o = RG_ACTIVE;
          default: kind_o = RG_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int unsigned WIDTH = 496
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irqc_sc_reg.sv
// Shared state bits with bus set/clear words and hardware set/clear vectors.
// Set takes precedence over clear on the same bit.
module irqc_sc_reg #(
  parameter  int unsigned NUM_BANKS = 16,
  parameter  int unsigned NUM_LINES = 496,
  localparam int unsigned VEC_W     = NUM_BANKS * 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [4:0]       bank_i,
  input  logic [31:0]      wdata_i,
  input  logic [VEC_W-1:0] hw_set_i,
  input  logic [VEC_W-1:0] hw_clr_i,
  output logic [VEC_W-1:0] state_o
);
  logic [VEC_W-1:0] bus_set, bus_clr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == 5'(b));
    assign bus_set[b*32 +: 32] = (set_we_i && hit) ? wdata_i : '0;
    assign bus_clr[b*32 +: 32] = (clr_we_i && hit) ? wdata_i : '0;
  end

  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    if (i < NUM_LINES) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          state_o[i] <= 1'b0;
        else if (bus_set[i] || hw_set_i[i])   state_o[i] <= 1'b1;
        else if (bus_clr[i] || hw_clr_i[i])   state_o[i] <= 1'b0;
      end
    end else begin : g_dead
      assign state_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
#(
  parameter  int unsigned NUM_LINES = 496,
  localparam int unsigned NUM_WORDS = NUM_LINES / 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  word_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  logic [NUM_LINES*PRIO_W-1:0] prio_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int unsigned LANE = i % 4;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        prio_q[i*PRIO_W +: PRIO_W] <= '0;
      else if (we_i && (32'(word_i) == i / 4))
        prio_q[i*PRIO_W +: PRIO_W] <= wdata_i[LANE*PRIO_W +: PRIO_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (32'(word_i) < NUM_WORDS) rdata_o = prio_q[32'(word_i)*32 +: 32];
  end
endmodule

// File: rtl/irqc_find.sv
// Two-level lowest-index search: per bank, then across banks.
module irqc_find #(
  parameter  int unsigned NUM_BANKS = 16,
  localparam int unsigned VEC_W     = NUM_BANKS * 32,
  localparam int unsigned ID_W      = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0] cand_i,
  output logic             valid_o,
  output logic [ID_W-1:0]  id_o
);
  logic [NUM_BANKS-1:0] bank_any;
  logic [4:0]           bank_low [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [31:0] word;
    assign word        = cand_i[b*32 +: 32];
    assign bank_any[b] = |word;
    always_comb begin
      bank_low[b] = '0;
      for (int i = 31; i >= 0; i--) if (word[i]) bank_low[b] = 5'(i);
    end
  end

  always_comb begin
    valid_o = |bank_any;
    id_o    = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--)
      if (bank_any[b]) id_o = ID_W'(b * 32) + ID_W'(bank_low[b]);
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irqc_pkg::*;
#(
  parameter  int unsigned NUM_BANKS = 16,
  localparam int unsigned NUM_LINES = line_count(NUM_BANKS),
  localparam int unsigned VEC_W     = NUM_BANKS * 32,
  localparam int unsigned ID_W      = $clog2(VEC_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [11:0]          bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic                 ack_valid_i,
  input  logic [ID_W-1:0]      ack_id_i,
  input  logic                 done_valid_i,
  input  logic [ID_W-1:0]      done_id_i,
  output logic                 find_valid_o,
  output logic [ID_W-1:0]      find_id_o,
  output logic                 any_pending_o
);
  reg_kind_e   kind;
  logic [4:0]  bank;
  logic [7:0]  word;
  logic        wr;
  logic [31:0] prio_rdata;

  logic [VEC_W-1:0] en_q, pend_q, act_q;
  logic [VEC_W-1:0] rise_vec, mask_vec, ack_vec, done_vec, zero_vec;
  logic [NUM_LINES-1:0] rise;

  irqc_decode u_dec (
    .addr_i (bus_addr_i),
    .kind_o (kind),
    .bank_o (bank),
    .word_o (word)
  );

  assign wr       = bus_req_i && bus_we_i;
  assign zero_vec = '0;

  irqc_edge #(.WIDTH(NUM_LINES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (irq_i),
    .rise_o (rise)
  );

  assign rise_vec = VEC_W'(rise);
  assign mask_vec = VEC_W'(mask_i);
  assign ack_vec  = (ack_valid_i && (32'(ack_id_i) < NUM_LINES))
                    ? (VEC_W'(1) << ack_id_i) : '0;
  assign done_vec = (done_valid_i && (32'(done_id_i) < NUM_LINES))
                    ? (VEC_W'(1) << done_id_i) : '0;

  irqc_sc_reg #(.NUM_BANKS(NUM_BANKS), .NUM_LINES(NUM_LINES)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (wr && kind == RG_SET_EN),
    .clr_we_i (wr && kind == RG_CLR_EN),
    .bank_i   (bank),
    .wdata_i  (bus_wdata_i),
    .hw_set_i (zero_vec),
    .hw_clr_i (zero_vec),
    .state_o  (en_q)
  );

  // new input edge beats a clear-pending write
  irqc_sc_reg #(.NUM_BANKS(NUM_BANKS), .NUM_LINES(NUM_LINES)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (wr && kind == RG_SET_PEND),
    .clr_we_i (wr && kind == RG_CLR_PEND),
    .bank_i   (bank),
    .wdata_i  (bus_wdata_i),
    .hw_set_i (rise_vec),
    .hw_clr_i (zero_vec),
    .state_o  (pend_q)
  );

  irqc_sc_reg #(.NUM_BANKS(NUM_BANKS), .NUM_LINES(NUM_LINES)) u_act (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (1'b0),
    .clr_we_i (1'b0),
    .bank_i   (bank),
    .wdata_i  (bus_wdata_i),
    .hw_set_i (ack_vec),
    .hw_clr_i (done_vec),
    .state_o  (act_q)
  );

  irqc_prio #(.NUM_LINES(NUM_LINES)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr && kind == RG_PRIO),
    .word_i  (word),
    .wdata_i (bus_wdata_i),
    .rdata_o (prio_rdata)
  );

  irqc_find #(.NUM_BANKS(NUM_BANKS)) u_find (
    .cand_i  (pend_q & ~mask_vec),
    .valid_o (find_valid_o),
    .id_o    (find_id_o)
  );

  assign any_pending_o = |(pend_q & en_q & ~mask_vec);

  logic [31:0] en_word, pend_word, act_word;

  always_comb begin
    en_word   = '0;
    pend_word = '0;
    act_word  = '0;
    if (32'(bank) < NUM_BANKS) begin
      en_word   = en_q[32'(bank)*32 +: 32];
      pend_word = pend_q[32'(bank)*32 +: 32];
      act_word  = act_q[32'(bank)*32 +: 32];
    end
  end

  always_comb begin
    case (kind)
      RG_TYPE:                  bus_rdata_o = 32'(NUM_BANKS - 1);
      RG_SET_EN, RG_CLR_EN:     bus_rdata_o = en_word;
      RG_SET_PEND, RG_CLR_PEND: bus_rdata_o = pend_word;
      RG_ACTIVE:                bus_rdata_o = act_word;
      RG_PRIO:                  bus_rdata_o = prio_rdata;
      default:                  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter  int unsigned NUM_BANKS = 16,
  localparam int unsigned NUM_LINES = line_count(NUM_BANKS),
  localparam int unsigned VEC_W     = NUM_BANKS * 32,
  localparam int unsigned ID_W      = $clog2(VEC_W)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_req_i,
  input logic                 bus_we_i,
  input logic [11:0]          bus_addr_i,
  input logic [31:0]          bus_rdata_o,
  input logic [NUM_LINES-1:0] irq_i,
  input logic [NUM_LINES-1:0] mask_i,
  input logic                 ack_valid_i,
  input logic                 done_valid_i,
  input logic                 find_valid_o,
  input logic [ID_W-1:0]      find_id_o,
  input logic                 any_pending_o,
  input logic [VEC_W-1:0]     pend_i,
  input logic [VEC_W-1:0]     act_i
);
  logic [NUM_LINES-1:0] irq_prev, ev_q;
  logic [VEC_W-1:0]     cand, below;
  logic                 state_reg, act_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_prev <= '0;
      ev_q     <= '0;
    end else begin
      irq_prev <= irq_i;
      ev_q     <= irq_i & ~irq_prev;
    end
  end

  assign cand      = pend_i & ~VEC_W'(mask_i);
  assign below     = (VEC_W'(1) << find_id_o) - VEC_W'(1);
  assign state_reg = (bus_addr_i[1:0] == 2'b00) &&
                     (bus_addr_i[11:7] >= 5'h02) && (bus_addr_i[11:7] <= 5'h06);
  assign act_wr    = bus_req_i && bus_we_i && state_reg && (bus_addr_i[11:7] == 5'h06);

  // R1
  type_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 12'h004) |-> (bus_rdata_o == 32'(NUM_BANKS - 1)));

  // R5
  beyond_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_reg && 32'(bus_addr_i[6:2]) >= NUM_BANKS) |-> (bus_rdata_o == '0));

  // R5
  half_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NUM_BANKS == MAX_BANKS && state_reg && bus_addr_i[6:2] == 5'd15)
      |-> (bus_rdata_o[31:16] == '0));

  // R7
  edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((VEC_W'(ev_q) & ~pend_i) == '0));

  // R8
  find_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    find_valid_o |-> cand[find_id_o]);

  // R8
  find_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    find_valid_o |-> ((cand & below) == '0));

  // R8
  find_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !find_valid_o |-> (cand == '0 && find_id_o == '0));

  // R9
  any_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pending_o |-> find_valid_o);

  // R10
  act_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_wr && !ack_valid_i && !done_valid_i) |=> $stable(act_i));
endmodule

bind irq_pend_ctrl irqc_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_req_i     (bus_req_i),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .bus_rdata_o   (bus_rdata_o),
  .irq_i         (irq_i),
  .mask_i        (mask_i),
  .ack_valid_i   (ack_valid_i),
  .done_valid_i  (done_valid_i),
  .find_valid_o  (find_valid_o),
  .find_id_o     (find_id_o),
  .any_pending_o (any_pending_o),
  .pend_i        (pend_q),
  .act_i         (act_q)
);

// File: tb/irq_pend_ctrl_test.sv
`timescale 1ns/1ps
module irq_pend_ctrl_test;
  localparam int NL = 496;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [NL-1:0] irq = '0, mask = '0;
  logic          ack_v = 1'b0, done_v = 1'b0;
  logic [8:0]    ack_id = '0, done_id = '0;
  logic          fvalid, anyp;
  logic [8:0]    fid;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_pend_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_i(irq), .mask_i(mask), .ack_valid_i(ack_v), .ack_id_i(ack_id),
    .done_valid_i(done_v), .done_id_i(done_id), .find_valid_o(fvalid),
    .find_id_o(fid), .any_pending_o(anyp)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; req = 1'b1; we = 1'b0;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 type", 12'h004, 32'h0000_000F);
    rd_chk("R11 enable zero", 12'h100, 32'h0);
    rd_chk("R11 pending zero", 12'h23C, 32'h0);
    rd_chk("R11 prio zero", 12'h400, 32'h0);
    #1 chk("R11 find invalid", {31'd0, fvalid}, 32'd0);
    chk("R11 any zero", {31'd0, anyp}, 32'd0);
  endtask

  task automatic t_enable;
    wr(12'h100, 32'h0000_00A5);
    rd_chk("R2 set read", 12'h100, 32'h0000_00A5);
    rd_chk("R2 clr alias read", 12'h180, 32'h0000_00A5);
    wr(12'h180, 32'h0000_0005);
    rd_chk("R2 clear", 12'h100, 32'h0000_00A0);
    wr(12'h100, 32'h0);
    rd_chk("R2 zero write no effect", 12'h100, 32'h0000_00A0);
    wr(12'h10C, 32'h0000_0080);
    rd_chk("R2 bank3", 12'h18C, 32'h0000_0080);
    wr(12'h180, 32'hFFFF_FFFF);
    wr(12'h18C, 32'hFFFF_FFFF);
    rd_chk("R2 clear all", 12'h100, 32'h0);
  endtask

  task automatic t_pend_bus;
    wr(12'h208, 32'h0000_0010);
    rd_chk("R3 set pending", 12'h288, 32'h0000_0010);
    #1 chk("R4 find line 68", {22'd0, fvalid, fid}, {22'd0, 1'b1, 9'd68});
    wr(12'h288, 32'h0000_0010);
    rd_chk("R3 clear pending", 12'h208, 32'h0);
    #1 chk("R8 none", {22'd0, fvalid, fid}, 32'd0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    @(negedge clk); irq[37] = 1'b1;
    @(negedge clk);
    rd_chk("R7 edge latches", 12'h204, 32'h0000_0020);
    wr(12'h284, 32'h0000_0020);
    @(negedge clk); @(negedge clk);
    rd_chk("R7 level not relatched", 12'h204, 32'h0);
    irq[37] = 1'b0;
    @(negedge clk);
    irq[37] = 1'b1;
    req = 1'b1; we = 1'b1; addr = 12'h284; wdata = 32'h0000_0020;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd(12'h204, d);
    chk("R7 event beats clear", d, 32'h0000_0020);
    wr(12'h284, 32'h0000_0020);
    irq[37] = 1'b0;
  endtask

  task automatic t_finder;
    wr(12'h200, 32'h0000_0008);
    wr(12'h204, 32'h0000_0100);
    wr(12'h224, 32'h0000_1000);
    #1 chk("R8 lowest 3", {22'd0, fvalid, fid}, {22'd0, 1'b1, 9'd3});
    chk("R9 no enable no any", {31'd0, anyp}, 32'd0);
    mask[3] = 1'b1;
    #1 chk("R8 masked to 40", {22'd0, fvalid, fid}, {22'd0, 1'b1, 9'd40});
    mask[40] = 1'b1;
    #1 chk("R8 masked to 300", {22'd0, fvalid, fid}, {22'd0, 1'b1, 9'd300});
    mask[300] = 1'b1;
    #1 chk("R8 all masked", {22'd0, fvalid, fid}, 32'd0);
    mask = '0;
    wr(12'h104, 32'h0000_0100);
    #1 chk("R9 enabled 40", {31'd0, anyp}, 32'd1);
    mask[40] = 1'b1;
    #1 chk("R9 enabled but masked", {31'd0, anyp}, 32'd0);
    mask = '0;
    wr(12'h280, 32'hFFFF_FFFF);
    wr(12'h284, 32'hFFFF_FFFF);
    wr(12'h2A4, 32'hFFFF_FFFF);
    wr(12'h184, 32'hFFFF_FFFF);
  endtask

  task automatic t_bank15;
    wr(12'h23C, 32'hFFFF_FFFF);
    rd_chk("R5 bank15 pending half", 12'h23C, 32'h0000_FFFF);
    #1 chk("R5 find 495 absent lower", {22'd0, fvalid, fid}, {22'd0, 1'b1, 9'd480});
    wr(12'h13C, 32'hFFFF_FFFF);
    rd_chk("R5 bank15 enable half", 12'h1BC, 32'h0000_FFFF);
    wr(12'h240, 32'hFFFF_FFFF);
    rd_chk("R5 bank16 reads zero", 12'h240, 32'h0);
    wr(12'h2BC, 32'hFFFF_FFFF);
    wr(12'h1BC, 32'hFFFF_FFFF);
    rd_chk("R5 bank15 cleared", 12'h23C, 32'h0);
  endtask

  task automatic t_prio;
    wr(12'h400, 32'h4433_2211);
    rd_chk("R6 word0", 12'h400, 32'h4433_2211);
    wr(12'h5EC, 32'hDEAD_BEEF);
    rd_chk("R6 last word", 12'h5EC, 32'hDEAD_BEEF);
    wr(12'h5F0, 32'h1234_5678);
    rd_chk("R6 unimplemented word", 12'h5F0, 32'h0);
    rd_chk("R6 word0 kept", 12'h400, 32'h4433_2211);
  endtask

  task automatic t_active;
    wr(12'h300, 32'hFFFF_FFFF);
    rd_chk("R10 bus write ignored", 12'h300, 32'h0);
    @(negedge clk); ack_v = 1'b1; ack_id = 9'd10;
    @(negedge clk); ack_v = 1'b0;
    rd_chk("R10 ack sets", 12'h300, 32'h0000_0400);
    done_v = 1'b1; done_id = 9'd10;
    @(negedge clk); done_v = 1'b0;
    rd_chk("R10 done clears", 12'h300, 32'h0);
    ack_v = 1'b1; ack_id = 9'd12; done_v = 1'b1; done_id = 9'd12;
    @(negedge clk); ack_v = 1'b0; done_v = 1'b0;
    rd_chk("R10 ack wins", 12'h300, 32'h0000_1000);
    ack_v = 1'b1; ack_id = 9'd500;
    @(negedge clk); ack_v = 1'b0;
    rd_chk("R10 out of range ignored", 12'h33C, 32'h0);
    ack_v = 1'b1; ack_id = 9'd495;
    @(negedge clk); ack_v = 1'b0;
    rd_chk("R10 line 495", 12'h33C, 32'h0000_8000);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_enable;
    t_pend_bus;
    t_irq;
    t_finder;
    t_bank15;
    t_prio;
    t_active;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule